// File: doc/BRIEF.md
# Single-Accumulator 8-bit Processor Core

This block is a small 8-bit processor. All arithmetic and logic runs through one accumulator. An index register supports array addressing, and a stack pointer supports a downward-growing stack. Three flags record the last result: zero, positive and carry. Instructions and data share one 256-byte memory, which is modelled inside the block as a synchronous array. A preload port fills that memory while the core is held in reset.

After reset is released, the core fetches one-byte opcodes starting at address 0. An opcode may be followed by a one-byte operand. The core forms operand addresses in an effective-address register and executes the instruction. Execution continues until the core halts or detects a fault. The result is reported on a status output whose five values are: still running, finished normally, input-read with no data available, input-read with a framing error, and an illegal opcode. Once the status leaves "running", the core executes nothing more until the next reset.

Top module: `acc8_core`

## Requirements
- R1: While rst_n is low at a clock edge, the core goes to status 0 (running) and clears PC, SP, accumulator, index register and all three flags. Memory contents are kept.
- R2: Instructions run in address order from 0. The PC increments by one for each opcode byte and each operand byte fetched, and it wraps from 0xFF to 0x00.
- R3: Opcode map, part 1 (operand instructions). For opcodes 0x10–0xB2, bits 7:4 select the operation: 1 load A, 2 load X, 3 store A, 4 add, 5 add with carry, 6 subtract, 7 subtract with borrow, 8 AND, 9 OR, A XOR, B compare. Bits 1:0 select the addressing mode: 0 immediate (the operand byte itself), 1 direct (memory at the operand), 2 indexed (memory at (operand + X) mod 256).
- R4: Add sets C to the carry out of bit 7. Add-with-carry adds C as well. Subtract sets C when a borrow occurs (A < M), and subtract-with-borrow also subtracts C. Compare sets the flags like subtract but leaves A unchanged.
- R5: Z is set when the destination register becomes 0. P is set when bit 7 of the destination is clear, so zero counts as positive. Both flags are updated by every ALU operation, every load, every index-register operation, increment and decrement of A, and input reads. Loads, index operations and increment/decrement of A leave C unchanged.
- R6: AND, OR and XOR clear C.
- R7: Store A writes the accumulator to the direct or indexed address. Store with immediate mode is illegal.
- R8: Push (0x09) first decrements SP and then writes A at the new SP. Pop (0x0A) first reads A from SP and then increments SP. After reset the first push goes to 0xFF.
- R9: Opcode map, part 2 (flow control). Each of these opcodes takes an absolute target operand: 0xC0 jump; 0xC1 branch if Z; 0xC2 branch if P; 0xC3 branch if C; 0xC4 call, which pushes the address after its operand the same way a push does. Return (0x0B) pops the PC.
- R10: Halt (0x01) sets status 1 (finished). After the status leaves running, the PC, A and the status hold their values until reset.
- R11: Input read (0x02) behaves as follows. If in_valid is low, it sets status 2 (no data). If in_valid is high and in_ferr is high, it sets status 3 (bad data). Otherwise it loads in_data into A.
- R12: Any opcode outside the map sets status 4 (bad opcode). This covers bits 1:0 = 3, bits 3:2 non-zero in operand groups, store-immediate, 0x0E–0x0F, 0xC5 and above, and 0xD0 and above. Registers other than the PC keep their values.
- R13: Other one-byte opcodes: 0x00 no-op, 0x03 increment A, 0x04 decrement A, 0x05 increment X, 0x06 decrement X, 0x07 copy A to X, 0x08 copy X to A, 0x0C clear C, 0x0D set C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pre_we | input | 1 | Preload write strobe into the internal memory |
| pre_addr | input | 8 | Preload address |
| pre_data | input | 8 | Preload byte |
| in_valid | input | 1 | An input byte is available for an input read |
| in_data | input | 8 | Input byte |
| in_ferr | input | 1 | Framing error on the input byte |
| status | output | 3 | 0 running, 1 finished, 2 no data, 3 bad data, 4 bad opcode |
| acc_q | output | 8 | Accumulator |
| idx_q | output | 8 | Index register |
| sp_q | output | 8 | Stack pointer |
| pc_q | output | 8 | Program counter |
| flag_z | output | 1 | Zero flag |
| flag_p | output | 1 | Positive flag |
| flag_c | output | 1 | Carry flag |

## Verification
Errors in internal state become visible at the ports through the program's results. A wrong effective address or index sum reaches the accumulator a few cycles later, when a load or ALU operation reads the wrong byte. A wrong stack pointer shows first on sp_q, and then on the value a pop or return restores. A bad flag update shows immediately on the flag outputs, and later as a branch that goes the wrong way, which moves the final PC. A decode mistake appears as the wrong status code within two cycles of the fetch.

// File: rtl/acc8_pkg.sv
// Package acc8_pkg: widths, opcode constants, status codes and decode
// helpers shared by the accumulator core and its ALU.
// Assumes an 8-bit datapath and a 256-byte shared code/data memory.
package acc8_pkg;

    localparam int unsigned DW = 8;
    localparam int unsigned AW = 8;

    // one-byte opcodes (bits 7:4 == 0)
    localparam logic [7:0] OP_NOP = 8'h00;
    localparam logic [7:0] OP_HLT = 8'h01;
    localparam logic [7:0] OP_INA = 8'h02;
    localparam logic [7:0] OP_INC = 8'h03;
    localparam logic [7:0] OP_DEC = 8'h04;
    localparam logic [7:0] OP_INX = 8'h05;
    localparam logic [7:0] OP_DEX = 8'h06;
    localparam logic [7:0] OP_TAX = 8'h07;
    localparam logic [7:0] OP_TXA = 8'h08;
    localparam logic [7:0] OP_PSH = 8'h09;
    localparam logic [7:0] OP_POP = 8'h0A;
    localparam logic [7:0] OP_RET = 8'h0B;
    localparam logic [7:0] OP_CLC = 8'h0C;
    localparam logic [7:0] OP_SEC = 8'h0D;

    // operand groups (bits 7:4)
    localparam logic [3:0] G_LDA  = 4'h1;
    localparam logic [3:0] G_LDX  = 4'h2;
    localparam logic [3:0] G_STA  = 4'h3;
    localparam logic [3:0] G_ADD  = 4'h4;
    localparam logic [3:0] G_ADC  = 4'h5;
    localparam logic [3:0] G_SUB  = 4'h6;
    localparam logic [3:0] G_SBC  = 4'h7;
    localparam logic [3:0] G_AND  = 4'h8;
    localparam logic [3:0] G_ORA  = 4'h9;
    localparam logic [3:0] G_XOR  = 4'hA;
    localparam logic [3:0] G_CMP  = 4'hB;
    localparam logic [3:0] G_FLOW = 4'hC;

    // addressing modes (bits 1:0)
    localparam logic [1:0] M_IMM = 2'd0;
    localparam logic [1:0] M_DIR = 2'd1;
    localparam logic [1:0] M_IDX = 2'd2;

    // flow-control selectors (bits 3:0 of group C)
    localparam logic [3:0] F_JMP  = 4'h0;
    localparam logic [3:0] F_BZ   = 4'h1;
    localparam logic [3:0] F_BP   = 4'h2;
    localparam logic [3:0] F_BC   = 4'h3;
    localparam logic [3:0] F_CALL = 4'h4;

    typedef enum logic [2:0] {
        ST_RUN     = 3'd0,
        ST_DONE    = 3'd1,
        ST_NODATA  = 3'd2,
        ST_BADDATA = 3'd3,
        ST_BADOP   = 3'd4
    } run_status_t;

    typedef enum logic [3:0] {
        ALU_PASS, ALU_ADD, ALU_ADC, ALU_SUB, ALU_SBC,
        ALU_AND, ALU_OR, ALU_XOR, ALU_INC, ALU_DEC
    } alu_op_t;

    typedef enum logic [2:0] {
        S_FETCH, S_DECODE, S_OPND, S_ADDR, S_MEMRD, S_STOP
    } cpu_state_t;

    // True when the opcode byte belongs to the fixed map.
    function automatic logic op_legal(logic [7:0] op);
        logic [3:0] g;
        g = op[7:4];
        if (g == 4'h0)
            return op <= OP_SEC;
        if (g >= G_LDA && g <= G_CMP)
            return (op[3:2] == 2'b00) && (op[1:0] != 2'd3) &&
                   !(g == G_STA && op[1:0] == M_IMM);
        if (g == G_FLOW)
            return op[3:0] <= F_CALL;
        return 1'b0;
    endfunction

    // ALU operation used by an operand group (compare reuses subtract).
    function automatic alu_op_t group_alu(logic [3:0] g);
        case (g)
            G_ADD:   return ALU_ADD;
            G_ADC:   return ALU_ADC;
            G_SUB:   return ALU_SUB;
            G_SBC:   return ALU_SBC;
            G_AND:   return ALU_AND;
            G_ORA:   return ALU_OR;
            G_XOR:   return ALU_XOR;
            G_CMP:   return ALU_SUB;
            default: return ALU_PASS;
        endcase
    endfunction

endpackage

// File: rtl/acc8_mem.sv
// Module acc8_mem: synchronous single-port byte memory shared by code and
// data, with a preload write port that takes priority over core writes.
// Assumes a read result one cycle after the address is presented; contents
// are not reset.
module acc8_mem #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wd,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write (preload first, then core) and registered read.
    always_ff @(posedge clk) begin
        if (pre_we)
            store[pre_addr] <= pre_data;
        else if (we)
            store[addr] <= wd;
        rdata <= store[addr];
    end

endmodule

// File: rtl/acc8_alu.sv
// Module acc8_alu: combinational 8-bit ALU for the accumulator core.
// Carry out is the add carry or the subtract borrow; logic ops clear it;
// pass, increment and decrement return the incoming carry unchanged.
module acc8_alu
    import acc8_pkg::*;
(
    input  alu_op_t       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          cin,
    output logic [DW-1:0] res,
    output logic          cout
);
    logic [DW:0] wide;

    // Select the operation and split the widened result.
    always_comb begin
        wide = {1'b0, b};
        cout = cin;
        case (op)
            ALU_ADD: wide = {1'b0, a} + {1'b0, b};
            ALU_ADC: wide = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
            ALU_SUB: wide = {1'b0, a} - {1'b0, b};
            ALU_SBC: wide = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, cin};
            ALU_AND: wide = {1'b0, a & b};
            ALU_OR:  wide = {1'b0, a | b};
            ALU_XOR: wide = {1'b0, a ^ b};
            ALU_INC: wide = {cin, a + 8'd1};
            ALU_DEC: wide = {cin, a - 8'd1};
            default: wide = {cin, b};
        endcase
        res  = wide[DW-1:0];
        cout = wide[DW];
    end

    // Borrow must match unsigned magnitude order.
    always_comb begin
        if (op == ALU_SUB)
            AST_SUB_BORROW: assert (cout == (a < b)); // R4
        if (op == ALU_AND || op == ALU_OR || op == ALU_XOR)
            AST_LOGIC_CLEARS_C: assert (!cout); // R6
    end

endmodule

// File: rtl/acc8_core.sv
// Module acc8_core: single-accumulator 8-bit processor with index register,
// downward stack, Z/P/C flags and a five-valued run status.
// Assumes the memory is preloaded while rst_n is low; runs from address 0
// after reset and stops for good once status leaves running.
module acc8_core
    import acc8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pre_we,
    input  logic [AW-1:0] pre_addr,
    input  logic [DW-1:0] pre_data,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          in_ferr,
    output logic [2:0]    status,
    output logic [DW-1:0] acc_q,
    output logic [DW-1:0] idx_q,
    output logic [AW-1:0] sp_q,
    output logic [AW-1:0] pc_q,
    output logic          flag_z,
    output logic          flag_p,
    output logic          flag_c
);
    cpu_state_t    state, n_state;
    run_status_t   st, n_st;
    logic [AW-1:0] pc, n_pc, sp, n_sp, ear, n_ear;
    logic [DW-1:0] ir, n_ir, a, n_a, x, n_x;
    logic          fz, fp, fc, n_fz, n_fp, n_fc;

    logic [AW-1:0] mem_addr;
    logic          mem_we;
    logic [DW-1:0] mem_wd, rdata;

    alu_op_t       alu_op;
    logic [DW-1:0] alu_res;
    logic          alu_c;
    logic          do_grp;
    logic          taken;

    acc8_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk      (clk),
        .addr     (mem_addr),
        .we       (mem_we),
        .wd       (mem_wd),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .rdata    (rdata)
    );

    acc8_alu u_alu (
        .op   (alu_op),
        .a    (a),
        .b    (rdata),
        .cin  (fc),
        .res  (alu_res),
        .cout (alu_c)
    );

    // Pick the ALU operation: inc/dec in decode, group op otherwise.
    always_comb begin
        if (state == S_DECODE)
            alu_op = (rdata == OP_INC) ? ALU_INC :
                     (rdata == OP_DEC) ? ALU_DEC : ALU_PASS;
        else
            alu_op = group_alu(ir[7:4]);
    end

    // Evaluate the branch condition of a flow-control opcode.
    always_comb begin
        case (ir[3:0])
            F_BZ:    taken = fz;
            F_BP:    taken = fp;
            F_BC:    taken = fc;
            default: taken = 1'b1;
        endcase
    end

    // Next-state, register and memory-port logic of the sequencer.
    always_comb begin
        n_state  = state;
        n_st     = st;
        n_pc     = pc;
        n_sp     = sp;
        n_ear    = ear;
        n_ir     = ir;
        n_a      = a;
        n_x      = x;
        n_fz     = fz;
        n_fp     = fp;
        n_fc     = fc;
        mem_addr = pc;
        mem_we   = 1'b0;
        mem_wd   = a;
        do_grp   = 1'b0;

        case (state)
            S_FETCH: begin
                mem_addr = pc;
                n_pc     = pc + 8'd1;
                n_state  = S_DECODE;
            end
            S_DECODE: begin
                n_ir    = rdata;
                n_state = S_FETCH;
                if (!op_legal(rdata)) begin
                    n_st    = ST_BADOP;
                    n_state = S_STOP;
                end else if (rdata[7:4] != 4'h0) begin
                    mem_addr = pc;
                    n_pc     = pc + 8'd1;
                    n_ear    = pc;
                    n_state  = S_OPND;
                end else begin
                    case (rdata)
                        OP_HLT: begin
                            n_st    = ST_DONE;
                            n_state = S_STOP;
                        end
                        OP_INA: begin
                            if (!in_valid) begin
                                n_st    = ST_NODATA;
                                n_state = S_STOP;
                            end else if (in_ferr) begin
                                n_st    = ST_BADDATA;
                                n_state = S_STOP;
                            end else begin
                                n_a  = in_data;
                                n_fz = (in_data == '0);
                                n_fp = ~in_data[DW-1];
                            end
                        end
                        OP_INC, OP_DEC: begin
                            n_a  = alu_res;
                            n_fz = (alu_res == '0);
                            n_fp = ~alu_res[DW-1];
                        end
                        OP_INX: begin
                            n_x  = x + 8'd1;
                            n_fz = (x == 8'hFF);
                            n_fp = ~(x + 8'd1) >> (DW-1) == 8'd1;
                        end
                        OP_DEX: begin
                            n_x  = x - 8'd1;
                            n_fz = (x == 8'h01);
                            n_fp = ~(x - 8'd1) >> (DW-1) == 8'd1;
                        end
                        OP_TAX: begin
                            n_x  = a;
                            n_fz = (a == '0);
                            n_fp = ~a[DW-1];
                        end
                        OP_TXA: begin
                            n_a  = x;
                            n_fz = (x == '0);
                            n_fp = ~x[DW-1];
                        end
                        OP_PSH: begin
                            mem_addr = sp - 8'd1;
                            mem_we   = 1'b1;
                            mem_wd   = a;
                            n_sp     = sp - 8'd1;
                        end
                        OP_POP, OP_RET: begin
                            mem_addr = sp;
                            n_sp     = sp + 8'd1;
                            n_state  = S_MEMRD;
                        end
                        OP_CLC: n_fc = 1'b0;
                        OP_SEC: n_fc = 1'b1;
                        default: ;
                    endcase
                end
            end
            S_OPND: begin
                n_state = S_FETCH;
                if (ir[7:4] == G_FLOW) begin
                    n_ear = rdata;
                    if (ir[3:0] == F_CALL) begin
                        mem_addr = sp - 8'd1;
                        mem_we   = 1'b1;
                        mem_wd   = pc;
                        n_sp     = sp - 8'd1;
                    end
                    if (taken)
                        n_pc = rdata;
                end else if (ir[1:0] == M_IMM) begin
                    do_grp = 1'b1;
                end else begin
                    n_ear   = (ir[1:0] == M_IDX) ? rdata + x : rdata;
                    n_state = S_ADDR;
                end
            end
            S_ADDR: begin
                mem_addr = ear;
                if (ir[7:4] == G_STA) begin
                    mem_we  = 1'b1;
                    mem_wd  = a;
                    n_state = S_FETCH;
                end else begin
                    n_state = S_MEMRD;
                end
            end
            S_MEMRD: begin
                n_state = S_FETCH;
                if (ir == OP_POP) begin
                    n_a  = rdata;
                    n_fz = (rdata == '0);
                    n_fp = ~rdata[DW-1];
                end else if (ir == OP_RET) begin
                    n_pc = rdata;
                end else begin
                    do_grp = 1'b1;
                end
            end
            default: n_state = S_STOP;
        endcase

        if (do_grp) begin
            case (ir[7:4])
                G_LDA: begin
                    n_a  = rdata;
                    n_fz = (rdata == '0);
                    n_fp = ~rdata[DW-1];
                end
                G_LDX: begin
                    n_x  = rdata;
                    n_fz = (rdata == '0);
                    n_fp = ~rdata[DW-1];
                end
                G_CMP: begin
                    n_fz = (alu_res == '0);
                    n_fp = ~alu_res[DW-1];
                    n_fc = alu_c;
                end
                default: begin
                    n_a  = alu_res;
                    n_fz = (alu_res == '0);
                    n_fp = ~alu_res[DW-1];
                    n_fc = alu_c;
                end
            endcase
        end
    end

    // Register update with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_FETCH;
            st    <= ST_RUN;
            pc    <= '0;
            sp    <= '0;
            ear   <= '0;
            ir    <= '0;
            a     <= '0;
            x     <= '0;
            fz    <= 1'b0;
            fp    <= 1'b0;
            fc    <= 1'b0;
        end else begin
            state <= n_state;
            st    <= n_st;
            pc    <= n_pc;
            sp    <= n_sp;
            ear   <= n_ear;
            ir    <= n_ir;
            a     <= n_a;
            x     <= n_x;
            fz    <= n_fz;
            fp    <= n_fp;
            fc    <= n_fc;
        end
    end

    assign status = st;
    assign acc_q  = a;
    assign idx_q  = x;
    assign sp_q   = sp;
    assign pc_q   = pc;
    assign flag_z = fz;
    assign flag_p = fp;
    assign flag_c = fc;

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |=> (pc == $past(pc) + 8'd1)); // R2

    AST_INDEX_EAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OPND && ir[7:4] != G_FLOW && ir[1:0] == M_IDX)
        |=> (ear == $past(rdata) + $past(x))); // R3

    AST_PUSH_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && rdata == OP_PSH) |=> (sp == $past(sp) - 8'd1)); // R8

    AST_HALT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && rdata == OP_HLT) |=> (status == ST_DONE)); // R10

    AST_STOP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (status != ST_RUN) |=> ($stable(status) && $stable(pc) && $stable(acc_q))); // R10

    AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DECODE && !op_legal(rdata)) |=> (status == ST_BADOP)); // R12

endmodule

// File: tb/acc8_core_test.sv
// Bench acc8_core_test: preloads programs through the preload port, runs the
// core until its status leaves running and compares results with values
// computed by bench functions. Random ALU programs plus directed corners.
module acc8_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_we = 1'b0;
    logic [7:0] pre_addr = '0, pre_data = '0;
    logic       in_valid = 1'b0, in_ferr = 1'b0;
    logic [7:0] in_data = '0;
    logic [2:0] status;
    logic [7:0] acc_q, idx_q, sp_q, pc_q;
    logic       flag_z, flag_p, flag_c;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [7:0] prog [256];

    acc8_core uut (
        .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_addr(pre_addr),
        .pre_data(pre_data), .in_valid(in_valid), .in_data(in_data),
        .in_ferr(in_ferr), .status(status), .acc_q(acc_q), .idx_q(idx_q),
        .sp_q(sp_q), .pc_q(pc_q), .flag_z(flag_z), .flag_p(flag_p),
        .flag_c(flag_c)
    );

    always #2 clk = ~clk;

    // Record one comparison.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Fill the program image with halt opcodes.
    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h01;
    endtask

    // Hold reset, preload the image, release reset and run to a stop.
    task automatic run_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            pre_we = 1'b1; pre_addr = 8'(i); pre_data = prog[i];
            @(negedge clk);
        end
        pre_we = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int n = 0; n < 2000 && status == 3'd0; n++) @(negedge clk);
    endtask

    // Expected {z,p,c,acc} for an operand-group ALU op.
    function automatic logic [10:0] model(input int g, input logic [7:0] av,
                                          input logic [7:0] bv, input logic ci);
        logic [8:0] t;
        logic [7:0] r, accv;
        case (g)
            4: t = av + bv;
            5: t = av + bv + ci;
            6: t = {1'b0, av} - {1'b0, bv};
            7: t = {1'b0, av} - {1'b0, bv} - ci;
            8: t = {1'b0, av & bv};
            9: t = {1'b0, av | bv};
            10: t = {1'b0, av ^ bv};
            default: t = {1'b0, av} - {1'b0, bv};
        endcase
        r = t[7:0];
        accv = (g == 11) ? av : r;
        return {r == 8'h00, ~r[7], t[8], accv};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd12345));

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 status", status, 0);
        chk("R1 pc/sp", {pc_q, sp_q}, 0);
        chk("R1 acc/x/flags", {acc_q, idx_q, flag_z, flag_p, flag_c}, 0);

        // R3 R4 R5 R6: random ALU programs in all three modes
        for (int it = 0; it < 40; it++) begin
            int g, mode;
            logic [7:0] av, bv, k;
            logic ci;
            logic [10:0] e;
            g = 4 + int'($urandom_range(0, 7));
            mode = int'($urandom_range(0, 2));
            av = 8'($urandom); bv = 8'($urandom); k = 8'($urandom);
            ci = 1'($urandom);
            if (it == 0) begin g = 4; av = 8'hFF; bv = 8'h01; ci = 0; mode = 0; end
            if (it == 1) begin g = 6; av = 8'h00; bv = 8'h01; ci = 0; mode = 1; end
            if (it == 2) begin g = 7; av = 8'h05; bv = 8'h05; ci = 1; mode = 2; end
            clear_prog();
            prog[0] = 8'h10; prog[1] = av;
            prog[2] = ci ? 8'h0D : 8'h0C;
            prog[3] = 8'h20; prog[4] = k;
            prog[5] = 8'(g << 4) | 8'(mode);
            prog[6] = (mode == 0) ? bv : (mode == 1) ? 8'h80 : 8'h90 - k;
            prog[7] = 8'h01;
            prog[8'h80] = bv; prog[8'h90] = bv;
            run_prog();
            e = model(g, av, bv, ci);
            chk("R4 R6 acc/flags", {acc_q, flag_z, flag_p, flag_c},
                {e[7:0], e[10], e[9], e[8]});
            chk("R3 R10 status/pc/x", {status, pc_q, idx_q}, {3'd1, 8'd8, k});
        end

        // R7: indexed store, direct reload
        clear_prog();
        prog[0]=8'h10; prog[1]=8'h5A; prog[2]=8'h20; prog[3]=8'h03;
        prog[4]=8'h32; prog[5]=8'hF0; prog[6]=8'h10; prog[7]=8'h00;
        prog[8]=8'h11; prog[9]=8'hF3; prog[10]=8'h01;
        run_prog();
        chk("R7 store/reload", acc_q, 8'h5A);

        // R8: push/pop order and first push at 0xFF
        clear_prog();
        prog[0]=8'h10; prog[1]=8'h11; prog[2]=8'h09; prog[3]=8'h10; prog[4]=8'h22;
        prog[5]=8'h09; prog[6]=8'h10; prog[7]=8'h00; prog[8]=8'h0A;
        prog[9]=8'h21; prog[10]=8'hFF; prog[11]=8'h01;
        run_prog();
        chk("R8 pop value", acc_q, 8'h22);
        chk("R8 first push at FF / sp", {idx_q, sp_q}, {8'h11, 8'hFF});

        // R9: branch if Z taken
        clear_prog();
        prog[0]=8'h10; prog[1]=8'h00; prog[2]=8'hC1; prog[3]=8'h06;
        prog[4]=8'h10; prog[5]=8'h01; prog[6]=8'h01;
        run_prog();
        chk("R9 bz taken", {acc_q, pc_q}, {8'h00, 8'h07});

        // R9 R5: branch if P not taken on 0x80
        clear_prog();
        prog[0]=8'h10; prog[1]=8'h80; prog[2]=8'hC2; prog[3]=8'h07;
        prog[4]=8'h10; prog[5]=8'h33; prog[6]=8'h01;
        prog[7]=8'h10; prog[8]=8'h44; prog[9]=8'h01;
        run_prog();
        chk("R9 bp not taken", acc_q, 8'h33);

        // R9: call and return
        clear_prog();
        prog[0]=8'hC4; prog[1]=8'h04; prog[2]=8'h01; prog[3]=8'h01;
        prog[4]=8'h10; prog[5]=8'h77; prog[6]=8'h0B;
        run_prog();
        chk("R9 call/ret", {acc_q, sp_q, pc_q}, {8'h77, 8'h00, 8'h03});

        // R2: PC wraps from FF to 00, branch if C after set-carry
        clear_prog();
        prog[0]=8'hC3; prog[1]=8'h04; prog[2]=8'hC0; prog[3]=8'hFF;
        prog[4]=8'h01; prog[8'hFF]=8'h0D;
        run_prog();
        chk("R2 pc wrap", {status, pc_q, flag_c}, {3'd1, 8'h05, 1'b1});

        // R13 R5: decrement X from 0, copy to A
        clear_prog();
        prog[0]=8'h20; prog[1]=8'h00; prog[2]=8'h06; prog[3]=8'h08; prog[4]=8'h01;
        run_prog();
        chk("R13 dex/txa", {acc_q, idx_q, flag_z, flag_p}, {8'hFF, 8'hFF, 2'b00});

        // R13 R5: increment X wraps to zero
        clear_prog();
        prog[0]=8'h20; prog[1]=8'hFF; prog[2]=8'h05; prog[3]=8'h01;
        run_prog();
        chk("R13 inx wrap", {idx_q, flag_z, flag_p}, {8'h00, 2'b11});

        // R13 R5: increment A across sign, carry unchanged
        clear_prog();
        prog[0]=8'h0D; prog[1]=8'h10; prog[2]=8'h7F; prog[3]=8'h03;
        prog[4]=8'h07; prog[5]=8'h04; prog[6]=8'h01;
        run_prog();
        chk("R13 inc/tax/dec", {acc_q, idx_q, flag_z, flag_p, flag_c},
            {8'h7F, 8'h80, 3'b011});

        // R10: halt freezes state
        clear_prog();
        run_prog();
        repeat (10) @(negedge clk);
        chk("R10 halt frozen", {status, pc_q}, {3'd1, 8'h01});

        // R12: undefined opcodes keep registers
        clear_prog();
        prog[0]=8'h10; prog[1]=8'h42; prog[2]=8'hFF;
        run_prog();
        chk("R12 badop FF", {status, acc_q}, {3'd4, 8'h42});
        clear_prog();
        prog[0]=8'h30; prog[1]=8'h00;
        run_prog();
        chk("R12 R7 store immediate", status, 4);
        clear_prog();
        prog[0]=8'h13;
        run_prog();
        chk("R12 mode 3", status, 4);

        // R11: input read outcomes
        clear_prog();
        prog[0]=8'h02;
        in_valid = 0; in_ferr = 0;
        run_prog();
        chk("R11 no data", status, 2);
        in_valid = 1; in_ferr = 1;
        run_prog();
        chk("R11 bad data", status, 3);
        in_valid = 1; in_ferr = 0; in_data = 8'h9C;
        run_prog();
        chk("R11 good data", {status, acc_q, flag_p}, {3'd1, 8'h9C, 1'b0});

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule